// File: doc/BRIEF.md
# SD Host Interrupt Status Register Bank

This block holds the interrupt state of an SD host controller. Single-cycle event pulses come in on one 32-bit vector from the controller's command, data, DMA and card-detect logic. A pulse is kept in the status register only when its bit is set in a latch-mask register. Software clears a kept bit by writing a one to that position. A second mask, the signal mask, chooses which kept bits raise the interrupt line. The line is registered.

Bit 15 of the status view is a derived error flag. It is the OR of all error sources, which sit in the upper half of the word. A handler can read the status, act on it, and write the same value back to clear exactly what it saw. Access uses a plain single-cycle register port with a combinational read. The logic that produces the events is not part of this block.

Top module: `sdh_irq_bank`

## Requirements
- R1: After reset the status, latch-mask and signal-mask registers all read zero and `irq_o` is low.
- R2: The status register sits at byte address 0x00, the latch mask at 0x04 and the signal mask at 0x08. Every other address reads zero. Both mask registers store only the source bit positions (mask 0x17FF51FF), and all other bits of the masks read zero.
- R3: The normal sources are bits 0–8, 12 and 14. The error sources are bits 16–26 and 28. A pulse on a source bit whose latch-mask bit is set makes that status bit read one after the next clock edge. The bit then stays set until software clears it.
- R4: A pulse on a bit whose latch-mask bit is clear leaves that status bit unchanged.
- R5: A write to the status register clears each status bit where the write data holds a one. It leaves every bit where the data holds a zero unchanged.
- R6: Status bit 15 reads one exactly when any error source bit (16–26, 28) is set. Writes cannot change bit 15 or any undefined bit (9–11, 13, 27, 29–31), and undefined bits always read zero.
- R7: If a latched pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R8: `irq_o` is high in the cycle after the AND of status and signal mask is nonzero, and low in the cycle after it is zero.
- R9: Writing zero to both masks and then writing back the value read from the status register leaves the status at zero and `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_pulse | input | 32 | One-cycle event pulses, one per status bit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the accessed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Each of the 32 bit positions is pulsed on its own with every latch bit enabled. This separates real source bits from undefined ones, and normal sources from error sources by whether bit 15 follows. Write-back clearing is checked after every single-bit pulse. Complementary latch-mask patterns show that only masked bits accumulate. Partial clears, including clears of bit 15 and of error bits one at a time, show how the summary flag tracks the remaining errors. The interrupt line is sampled both one edge and two edges after each mask or status change, which separates a registered output from a combinational one. A pulse and a clear that land on the same cycle show that setting takes priority.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
   localparam int unsigned          IRQ_W      = 32;
   localparam logic [IRQ_W-1:0]     NORM_SRC   = 32'h0000_51FF;
   localparam logic [IRQ_W-1:0]     ERR_SRC    = 32'h17FF_0000;
   localparam int unsigned          ERR_FLAG_POS = 15;

   typedef enum logic [1:0] {
      SEL_STAT  = 2'd0,
      SEL_LATCH = 2'd1,
      SEL_SIGNAL = 2'd2,
      SEL_NONE  = 2'd3
   } irq_sel_e;
endpackage

// File: rtl/sdh_irq_decode.sv
module sdh_irq_decode
   import sdh_irq_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned STAT_OFS   = 0,
   parameter int unsigned LATCH_OFS  = 4,
   parameter int unsigned SIGNAL_OFS = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output irq_sel_e          sel
);
   localparam logic [ADDR_W-1:0] A_STAT   = STAT_OFS[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_LATCH  = LATCH_OFS[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_SIGNAL = SIGNAL_OFS[ADDR_W-1:0];

   always_comb begin
      if (addr == A_STAT)        sel = SEL_STAT;
      else if (addr == A_LATCH)  sel = SEL_LATCH;
      else if (addr == A_SIGNAL) sel = SEL_SIGNAL;
      else                       sel = SEL_NONE;
   end
endmodule

// File: rtl/sdh_irq_mask_reg.sv
module sdh_irq_mask_reg #(
   parameter int unsigned     W    = 32,
   parameter logic [W-1:0]    KEEP = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata & KEEP;
   end
endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status #(
   parameter int unsigned  W        = 32,
   parameter logic [W-1:0] SRC_MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] ev,
   input  logic [W-1:0] latch_en,
   input  logic         clr_we,
   input  logic [W-1:0] clr_data,
   output logic [W-1:0] q
);
   logic [W-1:0] set_v;
   logic [W-1:0] clr_v;
   logic         unused_bits;

   assign set_v = ev & latch_en & SRC_MASK;
   assign clr_v = clr_we ? clr_data : '0;
   assign unused_bits = ^((set_v | clr_v) & ~SRC_MASK);

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (SRC_MASK[i]) begin : g_src
         logic cell_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cell_q <= 1'b0;
            else if (set_v[i]) cell_q <= 1'b1;
            else if (clr_v[i]) cell_q <= 1'b0;
         end
         assign q[i] = cell_q;
      end else begin : g_tie
         assign q[i] = 1'b0;
      end
   end
endmodule

// File: rtl/sdh_irq_bank.sv
module sdh_irq_bank
   import sdh_irq_pkg::*;
#(
   parameter int unsigned       REG_W      = IRQ_W,
   parameter int unsigned       ADDR_W     = 8,
   parameter int unsigned       STAT_OFS   = 0,
   parameter int unsigned       LATCH_OFS  = 4,
   parameter int unsigned       SIGNAL_OFS = 8,
   parameter logic [REG_W-1:0]  NORM_MASK  = NORM_SRC,
   parameter logic [REG_W-1:0]  ERR_MASK   = ERR_SRC,
   parameter int unsigned       FLAG_POS   = ERR_FLAG_POS,
   parameter bit                IRQ_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_W-1:0]  ev_pulse,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              irq_o
);
   localparam logic [REG_W-1:0] SRC_MASK = NORM_MASK | ERR_MASK;
   localparam logic [REG_W-1:0] FLAG_BIT = REG_W'(1) << FLAG_POS;

   if (FLAG_POS >= REG_W) begin : g_bad_flag
      $error("error flag position lies outside the register");
   end
   if ((NORM_MASK & ERR_MASK) != '0) begin : g_bad_overlap
      $error("normal and error source masks overlap");
   end
   if ((SRC_MASK & FLAG_BIT) != '0) begin : g_bad_flag_src
      $error("error flag position collides with a source bit");
   end
   if (STAT_OFS == LATCH_OFS || STAT_OFS == SIGNAL_OFS || LATCH_OFS == SIGNAL_OFS) begin : g_bad_ofs
      $error("register offsets must be distinct");
   end
   if (STAT_OFS >= (1 << ADDR_W) || LATCH_OFS >= (1 << ADDR_W) || SIGNAL_OFS >= (1 << ADDR_W)) begin : g_bad_addr
      $error("register offset does not fit the address width");
   end

   irq_sel_e         sel;
   logic [REG_W-1:0] st_q;
   logic [REG_W-1:0] lat_q;
   logic [REG_W-1:0] sig_q;
   logic [REG_W-1:0] st_view;
   logic             err_any;
   logic             irq_now;

   sdh_irq_decode #(
      .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS),
      .LATCH_OFS(LATCH_OFS), .SIGNAL_OFS(SIGNAL_OFS)
   ) u_dec (
      .addr(reg_addr),
      .sel (sel)
   );

   sdh_irq_mask_reg #(.W(REG_W), .KEEP(SRC_MASK)) u_latch (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (reg_wr && sel == SEL_LATCH),
      .wdata(reg_wdata),
      .q    (lat_q)
   );

   sdh_irq_mask_reg #(.W(REG_W), .KEEP(SRC_MASK)) u_signal (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (reg_wr && sel == SEL_SIGNAL),
      .wdata(reg_wdata),
      .q    (sig_q)
   );

   sdh_irq_status #(.W(REG_W), .SRC_MASK(SRC_MASK)) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev      (ev_pulse),
      .latch_en(lat_q),
      .clr_we  (reg_wr && sel == SEL_STAT),
      .clr_data(reg_wdata),
      .q       (st_q)
   );

   assign err_any = |(st_q & ERR_MASK);
   assign st_view = st_q | (err_any ? FLAG_BIT : '0);
   assign irq_now = |(st_view & sig_q);

   always_comb begin
      unique case (sel)
         SEL_STAT:   reg_rdata = st_view;
         SEL_LATCH:  reg_rdata = lat_q;
         SEL_SIGNAL: reg_rdata = sig_q;
         default:    reg_rdata = '0;
      endcase
   end

   if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_now;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = irq_now;
   end
endmodule

// File: rtl/sdh_irq_bank_chk.sv
module sdh_irq_bank_chk
   import sdh_irq_pkg::*;
#(
   parameter int unsigned REG_W    = IRQ_W,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned STAT_OFS = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [REG_W-1:0]  ev_pulse,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [REG_W-1:0]  reg_wdata,
   input logic [REG_W-1:0]  reg_rdata,
   input logic              irq_o,
   input logic [REG_W-1:0]  st_q,
   input logic [REG_W-1:0]  lat_q,
   input logic [REG_W-1:0]  sig_q
);
   localparam logic [ADDR_W-1:0] A_STAT = STAT_OFS[ADDR_W-1:0];
   localparam logic [REG_W-1:0]  DEFINED = NORM_SRC | ERR_SRC | (REG_W'(1) << ERR_FLAG_POS);

   logic [REG_W-1:0] hit;
   assign hit = ev_pulse & lat_q;

   // R3
   latched_event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((st_q & $past(hit)) == $past(hit)));

   // R4
   no_unlatched_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((st_q & ~$past(st_q) & ~$past(hit)) == '0));

   // R5
   w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_STAT) |=> ((st_q & $past(reg_wdata & ~hit)) == '0));

   // R6
   err_flag_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_STAT) |-> (reg_rdata[ERR_FLAG_POS] == |(reg_rdata & ERR_SRC)));

   // R6
   undefined_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_STAT) |-> ((reg_rdata & ~DEFINED) == '0));

   // R8
   irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_o == $past(|(reg_addr == A_STAT ? (reg_rdata & sig_q) : (st_q & sig_q)))));
endmodule

bind sdh_irq_bank sdh_irq_bank_chk #(
   .REG_W(32), .ADDR_W(8), .STAT_OFS(0)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ev_pulse (ev_pulse),
   .reg_wr   (reg_wr),
   .reg_addr (reg_addr),
   .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata),
   .irq_o    (irq_o),
   .st_q     (st_q),
   .lat_q    (lat_q),
   .sig_q    (sig_q)
);

// File: tb/sdh_irq_bank_tb.sv
module sdh_irq_bank_tb_top;
   localparam logic [31:0] NORM = 32'h0000_51FF;
   localparam logic [31:0] ERR  = 32'h17FF_0000;
   localparam logic [31:0] SRC  = NORM | ERR;
   localparam logic [31:0] FLAG = 32'h0000_8000;
   localparam logic [7:0]  A_ST = 8'h00, A_LAT = 8'h04, A_SIG = 8'h08;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ev_pulse = '0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_o;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   sdh_irq_bank dut_i (
      .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
   );

   function automatic logic [31:0] view(input logic [31:0] raw);
      return (raw & SRC) | (((raw & ERR) != 0) ? FLAG : 32'h0);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic pulse(input logic [31:0] v);
      ev_pulse = v;
      @(negedge clk);
      ev_pulse = '0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(A_ST, d);  chk("R1 status", d, 32'h0);
      rd(A_LAT, d); chk("R1 latch", d, 32'h0);
      rd(A_SIG, d); chk("R1 signal", d, 32'h0);
      chk("R1 irq", {31'h0, irq_o}, 32'h0);

      // R2 map and mask storage
      wr(A_LAT, 32'hFFFF_FFFF);
      wr(A_SIG, 32'hFFFF_FFFF);
      rd(A_LAT, d); chk("R2 latch keep", d, SRC);
      rd(A_SIG, d); chk("R2 signal keep", d, SRC);
      rd(8'h0C, d); chk("R2 hole 0x0C", d, 32'h0);
      rd(8'h40, d); chk("R2 hole 0x40", d, 32'h0);
      wr(A_SIG, 32'h0);

      // R3 / R5 / R6 single-bit sweep
      for (int b = 0; b < 32; b++) begin
         pulse(32'h1 << b);
         rd(A_ST, d); chk($sformatf("R3 R6 bit %0d set", b), d, view(32'h1 << b));
         wr(A_ST, d);
         rd(A_ST, d); chk($sformatf("R5 bit %0d cleared", b), d, 32'h0);
      end

      // R4 latch mask gates
      wr(A_LAT, 32'h0);
      pulse(32'hFFFF_FFFF);
      rd(A_ST, d); chk("R4 all masked", d, 32'h0);
      wr(A_LAT, 32'h0F0F_0F0F);
      pulse(32'hFFFF_FFFF);
      rd(A_ST, d); chk("R4 pattern A", d, view(32'h0F0F_0F0F));
      wr(A_LAT, 32'hF0F0_F0F0);
      pulse(32'hFFFF_FFFF);
      rd(A_ST, d); chk("R3 accumulate", d, view(32'hFFFF_FFFF));

      // R5 partial clear
      wr(A_ST, 32'h0000_00FF);
      rd(A_ST, d); chk("R5 partial", d, view(32'hFFFF_FF00));

      // R6 flag bit not writable, follows remaining errors
      wr(A_ST, FLAG);
      rd(A_ST, d); chk("R6 flag write ignored", d, view(32'hFFFF_FF00));
      wr(A_ST, ERR & ~32'h1000_0000);
      rd(A_ST, d); chk("R6 one error left", d, view((NORM & ~32'hFF) | 32'h1000_0000));
      wr(A_ST, 32'h1000_0000);
      rd(A_ST, d); chk("R6 no error", d, NORM & ~32'hFF);

      // R8 interrupt timing (status now 0x5100)
      wr(A_LAT, SRC);
      @(negedge clk);
      chk("R8 no signal", {31'h0, irq_o}, 32'h0);
      wr(A_SIG, 32'h0000_0100);
      chk("R8 registered lag", {31'h0, irq_o}, 32'h0);
      @(negedge clk);
      chk("R8 raised", {31'h0, irq_o}, 32'h1);
      wr(A_SIG, 32'h0000_0001);
      @(negedge clk);
      chk("R8 dropped", {31'h0, irq_o}, 32'h0);
      wr(A_SIG, 32'h0010_0000);
      pulse(32'h0010_0000);
      chk("R8 error lag", {31'h0, irq_o}, 32'h0);
      @(negedge clk);
      chk("R8 error raised", {31'h0, irq_o}, 32'h1);
      wr(A_ST, 32'h0010_0000);
      @(negedge clk);
      chk("R8 error cleared", {31'h0, irq_o}, 32'h0);

      // R7 set beats clear
      wr(A_ST, 32'hFFFF_FFFF);
      pulse(32'h0000_0018);
      ev_pulse = 32'h0000_0008;
      reg_addr = A_ST; reg_wdata = 32'h0000_0018; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; ev_pulse = '0; reg_wdata = '0;
      rd(A_ST, d); chk("R7 set wins", d, 32'h0000_0008);

      // R9 full shutdown sequence
      wr(A_SIG, SRC);
      pulse(SRC);
      @(negedge clk);
      chk("R9 pending before", {31'h0, irq_o}, 32'h1);
      wr(A_LAT, 32'h0);
      wr(A_SIG, 32'h0);
      rd(A_ST, d);
      wr(A_ST, d);
      rd(A_ST, d); chk("R9 status empty", d, 32'h0);
      @(negedge clk);
      chk("R9 irq low", {31'h0, irq_o}, 32'h0);

      finish_run();
   end
endmodule